// File: doc/BRIEF.md
# DMA Descriptor Fault Checker

This block screens a DMA channel's transfer descriptor at the moment it is activated. It also watches the bus error strobes that come back while a transfer is running. The descriptor checks cover four things. Both addresses and both per-access offsets must be aligned to their encoded access sizes. When chaining to a further descriptor is enabled, the next-descriptor pointer must sit on a 32-byte boundary. The minor-loop byte count must be non-zero and a whole multiple of the larger of the two access sizes. When linking is configured, the starting and current iteration counts must agree.

The first fault found is captured in a single error status word, together with the number of the offending channel. The word also holds a valid bit and a cancelled-transfer flag. The halt request output is raised at the same time. The word then stays frozen until software pulses the clear input, so later faults cannot overwrite the root cause. Descriptor fetch, arbitration and data movement are outside this block. It is meant to sit beside the channel engine, which presents the descriptor fields with a one-cycle `desc_vld` strobe.

An access-size code `k` (3 bits) means 2^k bytes, so code 0 is 1 byte and code 5 is 32 bytes.

Top module: `dma_desc_fault_chk`

## Requirements
- R1: With `desc_vld` high, source-address fault (status bit 7) is flagged when `src_addr` modulo 2^`src_size` is non-zero.
- R2: With `desc_vld` high, source-offset fault (status bit 6) is flagged when the 16-bit `src_off`, taken as two's complement, is not a multiple of 2^`src_size`.
- R3: Destination-address fault (bit 5) and destination-offset fault (bit 4) follow the same rules, using `dst_addr`, `dst_off` and `dst_size`.
- R4: Chain-pointer fault (bit 2) is flagged when `sg_en` is high and any of `next_desc_ptr[4:0]` is set. With `sg_en` low, the pointer is ignored.
- R5: Count fault (bit 3) is flagged when `minor_bytes` is zero, or is not a multiple of 2^max(`src_size`,`dst_size`).
- R6: Count fault (bit 3) is also flagged when `link_en` is high and `iter_begin` differs from `iter_cur`. With `link_en` low, the two counts are not compared.
- R7: A source bus error sets bit 1 and a destination bus error sets bit 0. Either one sets the cancelled flag (bit 13) and records `xfer_chan` as the channel.
- R8: The status word is laid out as {valid[14], cancelled[13], channel[12:8], flags[7:0]}. It is all zero while no fault is held. Descriptor fields are ignored while `desc_vld` is low.
- R9: The first fault is captured one clock after it is presented. Every flag raised in that cycle is captured. Later faults leave the word unchanged until it is cleared.
- R10: `clr_err` empties the word on the next clock. A fault presented in the same cycle as `clr_err` is captured instead.
- R11: `halt_req` is high exactly while the valid bit is set.
- R12: After reset the status word is zero and `halt_req` is low.
- R13: When a descriptor fault and a bus error arrive in the same cycle, all their flags are captured and the channel is taken from `xfer_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_err | input | 1 | Software clear of the error status word |
| desc_vld | input | 1 | Descriptor fields are being activated this cycle |
| desc_chan | input | 5 | Channel that owns the descriptor |
| src_addr | input | 32 | Source start address |
| dst_addr | input | 32 | Destination start address |
| src_off | input | 16 | Signed source offset applied per access |
| dst_off | input | 16 | Signed destination offset applied per access |
| src_size | input | 3 | Source access-size code (2^k bytes) |
| dst_size | input | 3 | Destination access-size code (2^k bytes) |
| sg_en | input | 1 | Chaining to a next descriptor is enabled |
| next_desc_ptr | input | 32 | Address of the next descriptor |
| minor_bytes | input | 16 | Bytes moved per minor loop |
| iter_begin | input | 15 | Starting iteration count |
| iter_cur | input | 15 | Current iteration count |
| link_en | input | 1 | Channel linking configured |
| src_bus_err | input | 1 | Bus error on a source read |
| dst_bus_err | input | 1 | Bus error on a destination write |
| xfer_chan | input | 5 | Channel of the transfer in flight |
| err_status | output | 15 | Error status word |
| halt_req | output | 1 | Halt request while a fault is held |

## Verification
Some properties are checked on every cycle. A held word does not change until a clear arrives. A clear with no fault present leaves an empty word. Each bus error, when nothing is held, produces its flag and the cancelled bit. A misaligned chain pointer with chaining on raises its flag. The halt request only rises after a fault was presented.

Other behaviour is only shown by the bench's scenarios. These are the arithmetic of every alignment rule, including negative offsets and the largest size code, and the rule of the larger size for the byte count. They also include which channel wins when a descriptor fault and a bus error coincide, and that fields with no effect (strobe low, chaining off, linking off) really leave the word empty.

// File: rtl/dma_fault_pkg.sv
package dma_fault_pkg;

    localparam int SZ_CODE_W = 3;

    // Fault flags, most significant first; bit order is the status word's low byte.
    typedef struct packed {
        logic src_addr;
        logic src_off;
        logic dst_addr;
        logic dst_off;
        logic count;
        logic chain_ptr;
        logic src_bus;
        logic dst_bus;
    } fault_flags_t;

    localparam int FLAGS_W = $bits(fault_flags_t);

endpackage

// File: rtl/dma_align_chk.sv
module dma_align_chk #(
    parameter int AW  = 32,
    parameter int OFW = 16,
    parameter int SZW = 3
) (
    input  logic [AW-1:0]  addr,
    input  logic [OFW-1:0] off,
    input  logic [SZW-1:0] size_code,
    output logic           addr_bad,
    output logic           off_bad
);
    logic [AW-1:0]  addr_mask;
    logic [OFW-1:0] off_mask;

    always_comb begin
        addr_mask = (AW'(1) << size_code) - AW'(1);
        off_mask  = (OFW'(1) << size_code) - OFW'(1);
        addr_bad  = |(addr & addr_mask);
        off_bad   = |(off & off_mask);
    end
endmodule

// File: rtl/dma_count_chk.sv
module dma_count_chk #(
    parameter int NB_W  = 16,
    parameter int CNT_W = 15,
    parameter int SZW   = 3
) (
    input  logic [NB_W-1:0]  minor_bytes,
    input  logic [SZW-1:0]   src_size,
    input  logic [SZW-1:0]   dst_size,
    input  logic             link_en,
    input  logic [CNT_W-1:0] iter_begin,
    input  logic [CNT_W-1:0] iter_cur,
    output logic             count_bad
);
    logic [SZW-1:0]  big_size;
    logic [NB_W-1:0] nb_mask;
    logic            nb_zero;
    logic            nb_ragged;
    logic            iter_mismatch;

    always_comb begin
        big_size      = (src_size > dst_size) ? src_size : dst_size;
        nb_mask       = (NB_W'(1) << big_size) - NB_W'(1);
        nb_zero       = (minor_bytes == '0);
        nb_ragged     = |(minor_bytes & nb_mask);
        iter_mismatch = link_en && (iter_begin != iter_cur);
        count_bad     = nb_zero || nb_ragged || iter_mismatch;
    end
endmodule

// File: rtl/dma_fault_reg.sv
module dma_fault_reg
    import dma_fault_pkg::*;
#(
    parameter int CH_W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_err,
    input  fault_flags_t new_flags,
    input  logic [CH_W-1:0] new_chan,
    input  logic         new_cancel,
    output fault_flags_t flags_q,
    output logic [CH_W-1:0] chan_q,
    output logic         cancel_q,
    output logic         valid_q
);
    typedef struct packed {
        logic            valid;
        logic            cancel;
        logic [CH_W-1:0] chan;
        fault_flags_t    flags;
    } fault_state_t;

    fault_state_t st_d, st_q;
    logic         any_new;

    always_comb begin
        any_new = |new_flags;
        st_d    = st_q;
        if (clr_err || !st_q.valid) begin
            if (any_new) begin
                st_d.valid  = 1'b1;
                st_d.cancel = new_cancel;
                st_d.chan   = new_chan;
                st_d.flags  = new_flags;
            end else if (clr_err) begin
                st_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_q  = st_q.flags;
    assign chan_q   = st_q.chan;
    assign cancel_q = st_q.cancel;
    assign valid_q  = st_q.valid;
endmodule

// File: rtl/dma_desc_fault_chk.sv
module dma_desc_fault_chk
    import dma_fault_pkg::*;
#(
    parameter int NUM_CH  = 32,
    parameter int AW      = 32,
    parameter int OFW     = 16,
    parameter int NB_W    = 16,
    parameter int CNT_W   = 15,
    parameter int SG_LOG2 = 5,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int STAT_W = FLAGS_W + CH_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_err,
    input  logic                 desc_vld,
    input  logic [CH_W-1:0]      desc_chan,
    input  logic [AW-1:0]        src_addr,
    input  logic [AW-1:0]        dst_addr,
    input  logic [OFW-1:0]       src_off,
    input  logic [OFW-1:0]       dst_off,
    input  logic [SZ_CODE_W-1:0] src_size,
    input  logic [SZ_CODE_W-1:0] dst_size,
    input  logic                 sg_en,
    input  logic [AW-1:0]        next_desc_ptr,
    input  logic [NB_W-1:0]      minor_bytes,
    input  logic [CNT_W-1:0]     iter_begin,
    input  logic [CNT_W-1:0]     iter_cur,
    input  logic                 link_en,
    input  logic                 src_bus_err,
    input  logic                 dst_bus_err,
    input  logic [CH_W-1:0]      xfer_chan,
    output logic [STAT_W-1:0]    err_status,
    output logic                 halt_req
);
    localparam int NSIDE = 2; // 0 = source, 1 = destination

    logic [AW-1:0]        side_addr [NSIDE];
    logic [OFW-1:0]       side_off  [NSIDE];
    logic [SZ_CODE_W-1:0] side_size [NSIDE];
    logic [NSIDE-1:0]     side_addr_bad;
    logic [NSIDE-1:0]     side_off_bad;

    assign side_addr[0] = src_addr;
    assign side_addr[1] = dst_addr;
    assign side_off[0]  = src_off;
    assign side_off[1]  = dst_off;
    assign side_size[0] = src_size;
    assign side_size[1] = dst_size;

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        dma_align_chk #(
            .AW (AW),
            .OFW(OFW),
            .SZW(SZ_CODE_W)
        ) u_align (
            .addr     (side_addr[s]),
            .off      (side_off[s]),
            .size_code(side_size[s]),
            .addr_bad (side_addr_bad[s]),
            .off_bad  (side_off_bad[s])
        );
    end

    logic count_bad;

    dma_count_chk #(
        .NB_W (NB_W),
        .CNT_W(CNT_W),
        .SZW  (SZ_CODE_W)
    ) u_count (
        .minor_bytes(minor_bytes),
        .src_size   (src_size),
        .dst_size   (dst_size),
        .link_en    (link_en),
        .iter_begin (iter_begin),
        .iter_cur   (iter_cur),
        .count_bad  (count_bad)
    );

    fault_flags_t    new_flags;
    logic [CH_W-1:0] new_chan;
    logic            new_cancel;
    logic            chain_bad;

    always_comb begin
        chain_bad            = sg_en && (|next_desc_ptr[SG_LOG2-1:0]);
        new_flags            = '0;
        new_flags.src_addr   = desc_vld && side_addr_bad[0];
        new_flags.src_off    = desc_vld && side_off_bad[0];
        new_flags.dst_addr   = desc_vld && side_addr_bad[1];
        new_flags.dst_off    = desc_vld && side_off_bad[1];
        new_flags.count      = desc_vld && count_bad;
        new_flags.chain_ptr  = desc_vld && chain_bad;
        new_flags.src_bus    = src_bus_err;
        new_flags.dst_bus    = dst_bus_err;
        new_cancel           = src_bus_err || dst_bus_err;
        // A transfer in flight names the channel that was cancelled.
        new_chan             = new_cancel ? xfer_chan : desc_chan;
    end

    fault_flags_t    flags_q;
    logic [CH_W-1:0] chan_q;
    logic            cancel_q;
    logic            valid_q;

    dma_fault_reg #(
        .CH_W(CH_W)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_err   (clr_err),
        .new_flags (new_flags),
        .new_chan  (new_chan),
        .new_cancel(new_cancel),
        .flags_q   (flags_q),
        .chan_q    (chan_q),
        .cancel_q  (cancel_q),
        .valid_q   (valid_q)
    );

    assign err_status = {valid_q, cancel_q, chan_q, flags_q};
    assign halt_req   = valid_q;
endmodule

// File: rtl/dma_desc_fault_chk_sva.sv
module dma_desc_fault_chk_sva #(
    parameter int AW      = 32,
    parameter int SG_LOG2 = 5,
    parameter int STAT_W  = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_err,
    input logic              desc_vld,
    input logic              sg_en,
    input logic [AW-1:0]     next_desc_ptr,
    input logic              src_bus_err,
    input logic              dst_bus_err,
    input logic [STAT_W-1:0] err_status,
    input logic              halt_req
);
    localparam int VB = STAT_W - 1;
    localparam int CB = STAT_W - 2;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status[VB] && !clr_err) |=> $stable(err_status));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !desc_vld && !src_bus_err && !dst_bus_err) |=> (err_status == '0));

    assert_src_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_req && src_bus_err) |=> (err_status[1] && err_status[CB] && err_status[VB]));

    assert_dst_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_req && dst_bus_err) |=> (err_status[0] && err_status[CB] && err_status[VB]));

    assert_chain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_req && desc_vld && sg_en && (|next_desc_ptr[SG_LOG2-1:0])) |=> err_status[2]);

    assert_halt_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> $past(desc_vld || src_bus_err || dst_bus_err));

    assert_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !err_status[VB] |-> (err_status == '0));
endmodule

bind dma_desc_fault_chk dma_desc_fault_chk_sva #(
    .AW     (AW),
    .SG_LOG2(SG_LOG2),
    .STAT_W (STAT_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_err      (clr_err),
    .desc_vld     (desc_vld),
    .sg_en        (sg_en),
    .next_desc_ptr(next_desc_ptr),
    .src_bus_err  (src_bus_err),
    .dst_bus_err  (dst_bus_err),
    .err_status   (err_status),
    .halt_req     (halt_req)
);

// File: tb/tb_dma_desc_fault_chk.sv
module tb_dma_desc_fault_chk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_err = 1'b0;
    logic        desc_vld = 1'b0;
    logic [4:0]  desc_chan = '0;
    logic [31:0] src_addr = '0;
    logic [31:0] dst_addr = '0;
    logic [15:0] src_off = '0;
    logic [15:0] dst_off = '0;
    logic [2:0]  src_size = '0;
    logic [2:0]  dst_size = '0;
    logic        sg_en = 1'b0;
    logic [31:0] next_desc_ptr = '0;
    logic [15:0] minor_bytes = 16'd4;
    logic [14:0] iter_begin = '0;
    logic [14:0] iter_cur = '0;
    logic        link_en = 1'b0;
    logic        src_bus_err = 1'b0;
    logic        dst_bus_err = 1'b0;
    logic [4:0]  xfer_chan = '0;
    logic [14:0] err_status;
    logic        halt_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk; // 250 MHz

    dma_desc_fault_chk dut (
        .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .desc_vld(desc_vld),
        .desc_chan(desc_chan), .src_addr(src_addr), .dst_addr(dst_addr),
        .src_off(src_off), .dst_off(dst_off), .src_size(src_size),
        .dst_size(dst_size), .sg_en(sg_en), .next_desc_ptr(next_desc_ptr),
        .minor_bytes(minor_bytes), .iter_begin(iter_begin), .iter_cur(iter_cur),
        .link_en(link_en), .src_bus_err(src_bus_err), .dst_bus_err(dst_bus_err),
        .xfer_chan(xfer_chan), .err_status(err_status), .halt_req(halt_req)
    );

    typedef struct packed {
        logic [31:0] sa;
        logic [31:0] da;
        logic [15:0] so;
        logic [15:0] doff;
        logic [2:0]  ssz;
        logic [2:0]  dsz;
        logic        sg;
        logic [31:0] np;
        logic [15:0] nb;
        logic [14:0] bi;
        logic [14:0] ci;
        logic        lk;
        logic [4:0]  ch;
        logic [7:0]  ef;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        // clean descriptor, R8
        '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 1'b0, 32'h0, 16'd16, 15'd4, 15'd4, 1'b0, 5'd3, 8'h00},
        // R1 source address off by two for 4-byte accesses
        '{32'h1002, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 1'b0, 32'h0, 16'd16, 15'd4, 15'd4, 1'b0, 5'd3, 8'h80},
        // R2 source offset of 2 with 4-byte accesses
        '{32'h1000, 32'h2000, 16'd2, 16'd4, 3'd2, 3'd2, 1'b0, 32'h0, 16'd16, 15'd4, 15'd4, 1'b0, 5'd6, 8'h40},
        // R3 destination address odd for 2-byte accesses
        '{32'h1000, 32'h2001, 16'd4, 16'd2, 3'd2, 3'd1, 1'b0, 32'h0, 16'd16, 15'd4, 15'd4, 1'b0, 5'd7, 8'h20},
        // R3 destination offset 6 with 4-byte accesses
        '{32'h1000, 32'h2000, 16'd4, 16'd6, 3'd2, 3'd2, 1'b0, 32'h0, 16'd16, 15'd4, 15'd4, 1'b0, 5'd8, 8'h10},
        // R4 chain pointer only 16-byte aligned
        '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 1'b1, 32'h3010, 16'd16, 15'd4, 15'd4, 1'b0, 5'd9, 8'h04},
        // R4 chain pointer 32-byte aligned: no fault
        '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 1'b1, 32'h3020, 16'd16, 15'd4, 15'd4, 1'b0, 5'd9, 8'h00},
        // R4 misaligned pointer ignored with chaining off
        '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 1'b0, 32'h3011, 16'd16, 15'd4, 15'd4, 1'b0, 5'd9, 8'h00},
        // R5 12 bytes is not a multiple of the larger 8-byte size
        '{32'h1001, 32'h2000, 16'd1, 16'd8, 3'd0, 3'd3, 1'b0, 32'h0, 16'd12, 15'd4, 15'd4, 1'b0, 5'd10, 8'h08},
        // R5 zero byte count
        '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 1'b0, 32'h0, 16'd0, 15'd4, 15'd4, 1'b0, 5'd11, 8'h08},
        // R6 linked, begin 5 vs current 4
        '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 1'b0, 32'h0, 16'd16, 15'd5, 15'd4, 1'b1, 5'd12, 8'h08},
        // R6 same mismatch without linking is ignored
        '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 1'b0, 32'h0, 16'd16, 15'd5, 15'd4, 1'b0, 5'd12, 8'h00},
        // R9 several flags in one descriptor, top channel
        '{32'h1001, 32'h2004, 16'd3, 16'd8, 3'd1, 3'd3, 1'b0, 32'h0, 16'd16, 15'd4, 15'd4, 1'b0, 5'd31, 8'hE0},
        // R2 R3 negative offsets: -4 aligned, -2 not
        '{32'h1000, 32'h2000, 16'hFFFC, 16'hFFFE, 3'd2, 3'd2, 1'b0, 32'h0, 16'd16, 15'd4, 15'd4, 1'b0, 5'd1, 8'h10},
        // R1 R5 32-byte accesses all aligned
        '{32'h1020, 32'h2040, 16'd32, 16'd32, 3'd5, 3'd5, 1'b0, 32'h0, 16'd64, 15'd4, 15'd4, 1'b0, 5'd2, 8'h00}
    };

    function automatic logic [14:0] word(logic v, logic c, logic [4:0] ch, logic [7:0] f);
        return {v, c, ch, f};
    endfunction

    function automatic string req_of(logic [7:0] f);
        if (f[7]) return "R1";
        if (f[6]) return "R2";
        if (f[5] || f[4]) return "R3";
        if (f[2]) return "R4";
        if (f[3]) return "R5";
        return "R8";
    endfunction

    task automatic check(string req, logic [14:0] exp);
        checks++;
        if (err_status !== exp) begin
            errors++;
            $display("FAIL %s: err_status=%h expected %h", req, err_status, exp);
        end
        checks++;
        if (halt_req !== exp[14]) begin
            errors++;
            $display("FAIL R11 (%s): halt_req=%b expected %b", req, halt_req, exp[14]);
        end
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_err = 1'b1;
        @(negedge clk);
        clr_err = 1'b0;
    endtask

    task automatic load(vec_t v);
        src_addr = v.sa; dst_addr = v.da; src_off = v.so; dst_off = v.doff;
        src_size = v.ssz; dst_size = v.dsz; sg_en = v.sg; next_desc_ptr = v.np;
        minor_bytes = v.nb; iter_begin = v.bi; iter_cur = v.ci; link_en = v.lk;
        desc_chan = v.ch;
    endtask

    task automatic present(vec_t v);
        @(negedge clk);
        load(v);
        desc_vld = 1'b1;
        @(negedge clk);
        desc_vld = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12", 15'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", 15'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            pulse_clear();
            present(VECS[i]);
            check(req_of(VECS[i].ef),
                  word(VECS[i].ef != 0, 1'b0, (VECS[i].ef != 0) ? VECS[i].ch : 5'd0, VECS[i].ef));
        end

        // R8 bad fields without the strobe are ignored
        pulse_clear();
        @(negedge clk);
        load(VECS[12]);
        sg_en = 1'b1; next_desc_ptr = 32'h7;
        repeat (2) @(negedge clk);
        check("R8", 15'h0);

        // R9 first fault latched, later fault ignored
        present(VECS[1]);
        check("R9", word(1'b1, 1'b0, 5'd3, 8'h80));
        present(VECS[4]);
        check("R9", word(1'b1, 1'b0, 5'd3, 8'h80));
        @(negedge clk);
        src_bus_err = 1'b1; xfer_chan = 5'd20;
        @(negedge clk);
        src_bus_err = 1'b0;
        check("R9", word(1'b1, 1'b0, 5'd3, 8'h80));

        // R10 clear alone empties the word
        pulse_clear();
        check("R10", 15'h0);

        // R7 source bus error
        @(negedge clk);
        src_bus_err = 1'b1; xfer_chan = 5'd9;
        @(negedge clk);
        src_bus_err = 1'b0;
        check("R7", word(1'b1, 1'b1, 5'd9, 8'h02));

        // R10 fault presented with clear is captured: destination bus error
        @(negedge clk);
        clr_err = 1'b1; dst_bus_err = 1'b1; xfer_chan = 5'd17;
        @(negedge clk);
        clr_err = 1'b0; dst_bus_err = 1'b0;
        check("R10", word(1'b1, 1'b1, 5'd17, 8'h01));

        // R7 both bus errors together
        pulse_clear();
        @(negedge clk);
        src_bus_err = 1'b1; dst_bus_err = 1'b1; xfer_chan = 5'd0;
        @(negedge clk);
        src_bus_err = 1'b0; dst_bus_err = 1'b0;
        check("R7", word(1'b1, 1'b1, 5'd0, 8'h03));

        // R13 descriptor fault and bus error in one cycle
        pulse_clear();
        @(negedge clk);
        load(VECS[1]);
        desc_chan = 5'd4; desc_vld = 1'b1;
        dst_bus_err = 1'b1; xfer_chan = 5'd12;
        @(negedge clk);
        desc_vld = 1'b0; dst_bus_err = 1'b0;
        check("R13", word(1'b1, 1'b1, 5'd12, 8'h81));

        // R12 reset in the middle empties the word
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12", 15'h0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule